// File: doc/BRIEF.md
# Oversampling ADC Result Accumulator and Formatter

This block sits between the result port of a 10-bit analog-to-digital converter and a 16-bit result register. Every time the converter signals a finished conversion, the block adds the unsigned 10-bit code to a running total. Once a programmable number of consecutive codes has been summed, it formats the total and publishes it as a 16-bit result with a one-clock valid pulse.

Formatting can place the code right-justified or left-justified, or shift the total right by one, two or three positions. Repeat counts of 4, 16 and 64 combined with shifts of 1, 2 and 3 turn the sum into an average with 11, 12 or 13 effective bits. Partial sums never reach the output. After each publication the block starts the next series from zero.

Top module: `ovs_result_fmt`

## Requirements
- R1: While `rst_n` is low and after its release, before any series completes, `result` is 0x0000 and `result_vld` is 0.
- R2: With repeat select 000 (one sample) and format select 000, the clock edge that accepts a code with `conv_done` high loads `result` with that code in bits 9:0 and zeros in bits 15:10. In the same edge, `result_vld` goes high for one cycle.
- R3: With one sample per series and format select 1xx (bit 2 set), `result` is the code shifted left by 6, and bits 5:0 are 0.
- R4: Repeat select maps 000→1, 001→4, 010→8, 011→16 and 100→32 accepted codes, and 101, 110 and 111→64. The published total is the unsigned sum of exactly that many accepted codes.
- R5: `result` and `result_vld` change only at the edge that accepts the last code of a series. At every other edge `result` holds its value and `result_vld` is 0, so partial sums are never visible.
- R6: Format select 001, 010 and 011 present the sum shifted right by 1, 2 and 3 (integer division by 2, 4 and 8) at every repeat count. Format select 000 presents the sum unshifted.
- R7: Format select 1xx combined with a repeat count above 1 presents the unshifted sum, as if right-justified.
- R8: After a publication, the next accepted code starts a new series with a sample count of zero and a sum of zero.
- R9: The repeat count is captured when the first code of a series is accepted, and later changes to `rpt_sel` within that series have no effect. `fmt_sel` is sampled at the edge that accepts the last code.
- R10: The following worked values hold. Code 1023 ×4 with shift 1 gives 0x07FE. Code 511 ×16 with shift 2 gives 0x07FC. Code 512 ×64 with shift 3 gives 0x1000. Code 1023 ×64 unshifted gives 0xFFC0.
- R11: Cycles with `conv_done` low neither add to the sum nor advance the sample count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Conversion finished; `conv_code` is valid this cycle |
| conv_code | input | 10 | Unsigned conversion code |
| rpt_sel | input | 3 | Repeat-count select |
| fmt_sel | input | 3 | Justify/shift select |
| result | output | 16 | Published formatted result |
| result_vld | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The hardest situation to reach is `rpt_sel` changing in the middle of a series. The stimulus alters the select after the first sample of a 4-sample series and again before its last sample, then checks that the published total still covers exactly four codes. A second case is a left-justify request combined with a multi-sample series. Gaps in `conv_done` are interleaved with back-to-back single-sample series, and a long stretch of mixed random selects, codes and strobe gaps is compared against a queue-based model on every clock.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int CNT_W = 7;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t rpt_decode(input logic [2:0] sel);
    cnt_t n;
    case (sel)
      3'b000:  n = cnt_t'(1);
      3'b001:  n = cnt_t'(4);
      3'b010:  n = cnt_t'(8);
      3'b011:  n = cnt_t'(16);
      3'b100:  n = cnt_t'(32);
      default: n = cnt_t'(64);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/ovs_sample_counter.sv
module ovs_sample_counter
  import ovs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [2:0] rpt_sel,
  output logic       last,
  output logic       single
);
  cnt_t cnt_q, cnt_d;
  cnt_t tgt_q, tgt_d;
  cnt_t tgt_cur;
  cnt_t cnt_inc;
  logic first;

  always_comb begin
    first   = (cnt_q == '0);
    tgt_cur = first ? rpt_decode(rpt_sel) : tgt_q;
    cnt_inc = cnt_q + 1'b1;
    single  = (tgt_cur == cnt_t'(1));
    last    = accept && (cnt_inc == tgt_cur);
  end

  always_comb begin
    cnt_d = cnt_q;
    tgt_d = tgt_q;
    if (accept) begin
      cnt_d = last ? '0 : cnt_inc;
      if (first) tgt_d = tgt_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= cnt_t'(1);
    end else if (accept) begin
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
    end
  end

  AST_CNT_BELOW_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < tgt_q)); // R4
  AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cnt_q)); // R11
  AST_TGT_HELD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(tgt_q)); // R9
endmodule

// File: rtl/ovs_accumulator.sv
module ovs_accumulator #(
  parameter int CODE_W = 10,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              last,
  input  logic [CODE_W-1:0] code,
  output logic [RES_W-1:0]  sum_next
);
  logic [RES_W-1:0] acc_q, acc_d;

  always_comb begin
    sum_next = acc_q + RES_W'(code);
    acc_d    = last ? '0 : sum_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (accept) acc_q <= acc_d;
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (acc_q == '0)); // R8
  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(acc_q)); // R11
endmodule

// File: rtl/ovs_formatter.sv
module ovs_formatter #(
  parameter int CODE_W = 10,
  parameter int RES_W  = 16,
  parameter int MAX_SH = 3
) (
  input  logic [RES_W-1:0] sum,
  input  logic [2:0]       fmt_sel,
  input  logic             single,
  output logic [RES_W-1:0] fmt_out
);
  localparam int LJ_SH = RES_W - CODE_W;

  logic [RES_W-1:0] shifted [MAX_SH+1];

  for (genvar s = 0; s <= MAX_SH; s++) begin : g_shift
    assign shifted[s] = sum >> s;
  end

  always_comb begin
    if (fmt_sel[2]) fmt_out = single ? (sum << LJ_SH) : sum;
    else            fmt_out = shifted[fmt_sel[1:0]];
  end

  always_comb begin
    if (fmt_sel[2] && single)
      AST_LEFT_LOW_CLEAR: assert (fmt_out[LJ_SH-1:0] == '0); // R3
    if (!fmt_sel[2] && fmt_sel[1:0] == 2'b11)
      AST_SHIFT3_TOP_CLEAR: assert (fmt_out[RES_W-1:RES_W-3] == '0); // R6
  end
endmodule

// File: rtl/ovs_result_fmt.sv
module ovs_result_fmt
  import ovs_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic [2:0]        rpt_sel,
  input  logic [2:0]        fmt_sel,
  output logic [RES_W-1:0]  result,
  output logic              result_vld
);
  logic             last, single;
  logic [RES_W-1:0] sum_next, fmt_val;
  logic [RES_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;

  ovs_sample_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (conv_done),
    .rpt_sel (rpt_sel),
    .last    (last),
    .single  (single)
  );

  ovs_accumulator #(.CODE_W(CODE_W), .RES_W(RES_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (conv_done),
    .last     (last),
    .code     (conv_code),
    .sum_next (sum_next)
  );

  ovs_formatter #(.CODE_W(CODE_W), .RES_W(RES_W)) u_fmt (
    .sum     (sum_next),
    .fmt_sel (fmt_sel),
    .single  (single),
    .fmt_out (fmt_val)
  );

  always_comb begin
    res_d = last ? fmt_val : res_q;
    vld_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (last) res_q <= res_d;
    end
  end

  assign result     = res_q;
  assign result_vld = vld_q;

  AST_VLD_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> $past(conv_done)); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld |-> $stable(result)); // R5
endmodule

// File: tb/ovs_result_fmt_bench.sv
module ovs_result_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_done;
  logic [9:0]  conv_code;
  logic [2:0]  rpt_sel;
  logic [2:0]  fmt_sel;
  logic [15:0] result;
  logic        result_vld;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int q[$];
  int m_tgt = 1;
  int exp_res = 0;
  int exp_vld = 0;

  always #5 clk = ~clk;

  ovs_result_fmt u_ovs_result_fmt (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_code(conv_code),
    .rpt_sel(rpt_sel), .fmt_sel(fmt_sel), .result(result), .result_vld(result_vld)
  );

  function automatic int n_of(int r);
    int t[8] = '{1, 4, 8, 16, 32, 64, 64, 64};
    return t[r];
  endfunction

  function automatic int fmt_of(int s, int n, int f);
    if (f >= 4) return (n == 1) ? s * 64 : s;
    return s / (1 << f);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit d, int c, int r, int f, string tag);
    conv_done = d; conv_code = 10'(c); rpt_sel = 3'(r); fmt_sel = 3'(f);
    @(posedge clk);
    exp_vld = 0;
    if (d) begin
      if (q.size() == 0) m_tgt = n_of(r);
      q.push_back(c);
      if (q.size() == m_tgt) begin
        int s = 0;
        foreach (q[i]) s += q[i];
        exp_res = fmt_of(s, m_tgt, f);
        exp_vld = 1;
        q.delete();
      end
    end
    @(negedge clk);
    chk({tag, " result"}, int'(result), exp_res);
    chk({tag, " valid"}, int'(result_vld), exp_vld);
  endtask

  task automatic series(int n, int c, int r, int f, string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, c, r, f, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; conv_done = 1'b0; conv_code = '0; rpt_sel = '0; fmt_sel = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset valid", int'(result_vld), 0);
    rst_n = 1'b1;
    cyc(1'b0, 0, 0, 0, "R1");
    chk("R1 after release", int'(result), 0);

    series(1, 1023, 0, 0, "R2");
    chk("R2 full scale right", int'(result), 16'h03FF);
    series(1, 512, 0, 0, "R2");
    chk("R2 mid right", int'(result), 16'h0200);
    series(1, 1023, 0, 4, "R3");
    chk("R3 full scale left", int'(result), 16'hFFC0);
    series(1, 256, 0, 7, "R3");
    chk("R3 quarter left", int'(result), 16'h4000);

    series(4, 1023, 1, 1, "R10");
    chk("R10 x4 shift1", int'(result), 16'h07FE);
    series(16, 511, 3, 2, "R10");
    chk("R10 x16 shift2", int'(result), 16'h07FC);
    series(64, 512, 5, 3, "R10");
    chk("R10 x64 shift3", int'(result), 16'h1000);
    series(64, 1023, 7, 0, "R10");
    chk("R10 x64 unshifted", int'(result), 16'hFFC0);

    series(8, 100, 2, 0, "R4");
    chk("R4 x8 sum", int'(result), 800);
    series(32, 1000, 4, 0, "R4");
    chk("R4 x32 sum", int'(result), 32000);
    series(64, 1, 6, 0, "R4");
    chk("R4 sel110 is 64", int'(result), 64);

    series(1, 1023, 0, 3, "R6");
    chk("R6 single shift3", int'(result), 127);
    series(4, 1023, 1, 5, "R7");
    chk("R7 left with x4", int'(result), 16'h0FFC);

    cyc(1'b1, 10, 1, 0, "R9");
    cyc(1'b1, 20, 0, 0, "R9");
    cyc(1'b0, 0, 5, 0, "R11");
    cyc(1'b1, 30, 5, 0, "R9");
    chk("R5 no partial", int'(result_vld), 0);
    cyc(1'b1, 40, 0, 2, "R9");
    chk("R9 rpt captured, fmt at last", int'(result), 25);
    series(1, 7, 0, 0, "R8");
    chk("R8 fresh series", int'(result), 7);

    for (int i = 0; i < 3000; i++) begin
      bit d = ($urandom % 10) < 7;
      cyc(d, int'($urandom % 1024), int'($urandom % 8), int'($urandom % 8), "R4 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule